// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides, for one eight-line interrupt unit, which request (if any) should be raised toward the processor. It takes the registered pending, mask and in-service vectors from the surrounding unit. It forms the set of unmasked pending lines and ranks them relative to a rotating base line. The best candidate is raised only when it strictly outranks the best line already in service. The result is a valid flag and the winning line number. Both are combinational from the inputs and the base register.

The base line is held in a register inside the block. Two single-cycle commands update it. A rotate-on-service command moves the base to one past the serviced line, so that line drops to the lowest priority. A set-priority command moves the base to one past a supplied 3-bit value. On a master unit with special nesting enabled, the cascade line's in-service bit does not block requests. This lets a second request through the cascade line while an earlier one is still being serviced.

Top module: `pri_rot_resolver`

## Requirements
- R1: The candidate set is the pending vector with every masked line removed. A line whose mask bit is 1 never wins and never makes the valid flag 1 on its own.
- R2: A line's rank is (line - base) mod 8, with rank 0 highest. Among the candidates, the line with the lowest rank is reported on `req_line`, in the same cycle as the inputs change.
- R3: When the candidate set is empty, `req_valid` is 0 whatever the in-service vector holds.
- R4: `req_valid` is 1 only if the best candidate's rank is strictly lower than the rank of the best effective in-service line. A tie (the same line both pending and in service) or a better in-service line gives 0.
- R5: With no effective in-service bit, any non-empty candidate set makes `req_valid` 1.
- R6: When both `nest_en` and `is_master` are 1, in-service bit 2 (the cascade line) is ignored in the in-service rank. If either flag is 0, that bit counts like any other.
- R7: A pulse on `svc_rot_load` with line L sets the base to (L + 1) mod 8 at the next clock edge.
- R8: A pulse on `setpri_load` with value V sets the base to (V + 1) mod 8 at the next clock edge.
- R9: When both commands pulse in the same cycle, the set-priority command decides the new base.
- R10: Reset sets the base to 0. Without a command pulse, the base keeps its value across clock edges regardless of the vector inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_vec | input | 8 | Registered pending request vector |
| mask_vec | input | 8 | Mask vector, 1 blocks the line |
| insvc_vec | input | 8 | In-service vector |
| nest_en | input | 1 | Special nesting mode enable |
| is_master | input | 1 | Unit is the master of a cascade |
| svc_rot_load | input | 1 | Rotate-on-service command strobe |
| svc_line | input | 3 | Line serviced with rotation |
| setpri_load | input | 1 | Set-priority command strobe |
| setpri_val | input | 3 | Value for the set-priority command |
| req_valid | output | 1 | A request should be raised |
| req_line | output | 3 | Winning line, meaningful when req_valid is 1 |
| rot_base | output | 3 | Current rotation base line |

## Verification
Single-line patterns with the base swept through all eight values show whether the wrap of the rank arithmetic is correct. A fully pending vector at each base pins the winner to the base line itself. Pairs of pending lines placed on both sides of the base separate a modulo rank from a plain lowest-index pick. Equal, higher and lower in-service lines against one pending line catch the strict-compare boundary. The cascade bit is tried with each combination of the two nesting flags. A long pseudo-random sweep of vectors and bases is then checked against an independent per-line rank model.

// File: rtl/pri_rot_pkg.sv
package pri_rot_pkg;
  // number of lines must be a power of two so the rank wraps by truncation
  localparam int unsigned PRI_LINES = 8;
  localparam int unsigned PRI_LW    = $clog2(PRI_LINES);
  localparam int unsigned PRI_RW    = PRI_LW + 1;

  typedef logic [PRI_LINES-1:0] pri_vec_t;
  typedef logic [PRI_LW-1:0]    pri_line_t;
  typedef logic [PRI_RW-1:0]    pri_rank_t;

  typedef enum logic [1:0] {
    BASE_HOLD    = 2'd0,
    BASE_SERVICE = 2'd1,
    BASE_SETPRI  = 2'd2
  } base_op_e;

  // out[r] is the bit of the line that sits at rank r
  function automatic pri_vec_t rotate_to_base(pri_vec_t v, pri_line_t b);
    pri_vec_t  o;
    pri_line_t idx;
    o = '0;
    for (int r = 0; r < PRI_LINES; r++) begin
      idx  = pri_line_t'(b + pri_line_t'(r));
      o[r] = v[idx];
    end
    return o;
  endfunction

  // lowest set position, PRI_LINES when empty
  function automatic pri_rank_t first_set(pri_vec_t v);
    pri_rank_t rk;
    rk = pri_rank_t'(PRI_LINES);
    for (int r = PRI_LINES - 1; r >= 0; r--) begin
      if (v[r]) rk = pri_rank_t'(r);
    end
    return rk;
  endfunction

  function automatic pri_line_t rank_to_line(pri_rank_t rk, pri_line_t b);
    return pri_line_t'(rk[PRI_LW-1:0] + b);
  endfunction

  function automatic pri_line_t line_after(pri_line_t l);
    return pri_line_t'(l + pri_line_t'(1));
  endfunction
endpackage

// File: rtl/pri_rank_enc.sv
module pri_rank_enc
  import pri_rot_pkg::*;
(
  input  pri_vec_t  vec_in,
  input  pri_line_t base_in,
  output pri_rank_t rank_out
);
  pri_vec_t rotated;

  always_comb begin
    rotated  = rotate_to_base(vec_in, base_in);
    rank_out = first_set(rotated);
  end
endmodule

// File: rtl/pri_base_reg.sv
module pri_base_reg
  import pri_rot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      svc_load,
  input  pri_line_t svc_line,
  input  logic      set_load,
  input  pri_line_t set_val,
  output pri_line_t base_q
);
  base_op_e  base_op;
  pri_line_t base_d;

  always_comb begin
    if (set_load)      base_op = BASE_SETPRI;
    else if (svc_load) base_op = BASE_SERVICE;
    else               base_op = BASE_HOLD;
  end

  always_comb begin
    case (base_op)
      BASE_SETPRI:  base_d = line_after(set_val);
      BASE_SERVICE: base_d = line_after(svc_line);
      default:      base_d = base_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  // R8
  setpri_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_load |=> (base_q == pri_line_t'($past(set_val) + 3'd1)));

  // R7
  service_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_load && !set_load) |=> (base_q == pri_line_t'($past(svc_line) + 3'd1)));

  // R10
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_load && !set_load) |=> $stable(base_q));
endmodule

// File: rtl/pri_rot_resolver.sv
module pri_rot_resolver
  import pri_rot_pkg::*;
#(
  parameter int unsigned CASC_LINE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pend_vec,
  input  logic [7:0] mask_vec,
  input  logic [7:0] insvc_vec,
  input  logic       nest_en,
  input  logic       is_master,
  input  logic       svc_rot_load,
  input  logic [2:0] svc_line,
  input  logic       setpri_load,
  input  logic [2:0] setpri_val,
  output logic       req_valid,
  output logic [2:0] req_line,
  output logic [2:0] rot_base
);
  localparam int unsigned N_ENC = 2;
  localparam int unsigned ENC_CAND = 0;
  localparam int unsigned ENC_ISV  = 1;

  pri_vec_t  cand_vec;
  pri_vec_t  isv_eff;
  logic      casc_ignored;
  pri_rank_t cand_rank;
  pri_rank_t isv_rank;
  pri_line_t base_q;

  pri_vec_t  enc_vec  [N_ENC];
  pri_rank_t enc_rank [N_ENC];

  always_comb begin
    cand_vec     = pend_vec & ~mask_vec;
    casc_ignored = nest_en & is_master;
    isv_eff      = insvc_vec;
    if (casc_ignored) isv_eff[CASC_LINE] = 1'b0;
  end

  assign enc_vec[ENC_CAND] = cand_vec;
  assign enc_vec[ENC_ISV]  = isv_eff;

  for (genvar g = 0; g < N_ENC; g++) begin : g_enc
    pri_rank_enc u_enc (
      .vec_in   (enc_vec[g]),
      .base_in  (base_q),
      .rank_out (enc_rank[g])
    );
  end

  assign cand_rank = enc_rank[ENC_CAND];
  assign isv_rank  = enc_rank[ENC_ISV];

  pri_base_reg u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc_load (svc_rot_load),
    .svc_line (svc_line),
    .set_load (setpri_load),
    .set_val  (setpri_val),
    .base_q   (base_q)
  );

  assign req_valid = (cand_rank < isv_rank);
  assign req_line  = rank_to_line(cand_rank, base_q);
  assign rot_base  = base_q;

  // R1
  win_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (pend_vec[req_line] && !mask_vec[req_line]));

  // R3
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & ~mask_vec) == 8'h00) |-> !req_valid);

  // R4
  no_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !isv_eff[req_line]);

  // R5
  idle_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((isv_eff == '0) && (cand_vec != '0)) |-> req_valid);

  // R6
  casc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nest_en && is_master) |-> (isv_eff == insvc_vec));
endmodule

// File: tb/tb_pri_rot_resolver.sv
`timescale 1ns/1ps
module tb_pri_rot_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pend_vec = '0, mask_vec = '0, insvc_vec = '0;
  logic       nest_en = 1'b0, is_master = 1'b0;
  logic       svc_rot_load = 1'b0, setpri_load = 1'b0;
  logic [2:0] svc_line = '0, setpri_val = '0;
  logic       req_valid;
  logic [2:0] req_line, rot_base;

  int errors = 0;
  int checks = 0;
  logic [2:0] exp_base = '0;

  always #2.5 clk = ~clk;

  pri_rot_resolver dut (
    .clk(clk), .rst_n(rst_n), .pend_vec(pend_vec), .mask_vec(mask_vec),
    .insvc_vec(insvc_vec), .nest_en(nest_en), .is_master(is_master),
    .svc_rot_load(svc_rot_load), .svc_line(svc_line),
    .setpri_load(setpri_load), .setpri_val(setpri_val),
    .req_valid(req_valid), .req_line(req_line), .rot_base(rot_base)
  );

  // independent model: per-line distance from the base, keep the smallest
  function automatic logic [3:0] model(logic [7:0] p, logic [7:0] m, logic [7:0] i,
                                       logic ne, logic ms, logic [2:0] b);
    logic [7:0] c, s;
    int bc, bi, bl, d;
    c = p & ~m;
    s = i;
    if (ne && ms) s[2] = 1'b0;
    bc = 8; bi = 8; bl = 0;
    for (int k = 0; k < 8; k++) begin
      d = (k - int'(b) + 8) % 8;
      if (c[k] && d < bc) begin bc = d; bl = k; end
      if (s[k] && d < bi) bi = d;
    end
    return {(bc < bi), 3'(bl)};
  endfunction

  task automatic check_out(string tag);
    logic [3:0] e;
    e = model(pend_vec, mask_vec, insvc_vec, nest_en, is_master, exp_base);
    checks++;
    if (req_valid !== e[3] || (e[3] && req_line !== e[2:0])) begin
      errors++;
      $display("FAIL %s: valid=%b line=%0d expected valid=%b line=%0d",
               tag, req_valid, req_line, e[3], e[2:0]);
    end
  endtask

  task automatic check_valid(string tag, logic ev, logic [2:0] el);
    checks++;
    if (req_valid !== ev || (ev && req_line !== el)) begin
      errors++;
      $display("FAIL %s: valid=%b line=%0d expected valid=%b line=%0d",
               tag, req_valid, req_line, ev, el);
    end
  endtask

  task automatic check_base(string tag);
    checks++;
    if (rot_base !== exp_base) begin
      errors++;
      $display("FAIL %s: base=%0d expected %0d", tag, rot_base, exp_base);
    end
  endtask

  task automatic apply(logic [7:0] p, logic [7:0] m, logic [7:0] i, logic ne, logic ms);
    @(negedge clk);
    pend_vec = p; mask_vec = m; insvc_vec = i; nest_en = ne; is_master = ms;
    #1;
  endtask

  task automatic set_pri(logic [2:0] v);
    @(negedge clk);
    setpri_val = v; setpri_load = 1'b1;
    @(negedge clk);
    setpri_load = 1'b0;
    exp_base = 3'(v + 3'd1);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    exp_base = 3'd0;
    check_base("R10 reset base");
    check_valid("R3 reset quiet", 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_mask;
    set_pri(3'd7);
    apply(8'h01, 8'h01, 8'h00, 0, 0); check_valid("R1 masked only", 1'b0, 3'd0);
    apply(8'h03, 8'h01, 8'h00, 0, 0); check_valid("R1 mask skips line0", 1'b1, 3'd1);
    apply(8'hFF, 8'h7F, 8'h00, 0, 0); check_valid("R1 only line7 open", 1'b1, 3'd7);
  endtask

  task automatic t_rank;
    set_pri(3'd4);
    apply(8'h11, 8'h00, 8'h00, 0, 0); check_valid("R2 base5 wrap", 1'b1, 3'd0);
    apply(8'h60, 8'h00, 8'h00, 0, 0); check_valid("R2 base5 at base", 1'b1, 3'd5);
    apply(8'h18, 8'h00, 8'h00, 0, 0); check_valid("R2 base5 pair", 1'b1, 3'd3);
    for (int b = 0; b < 8; b++) begin
      set_pri(3'(b + 7));
      apply(8'hFF, 8'h00, 8'h00, 0, 0); check_valid("R2 full vector wins base", 1'b1, 3'(b));
    end
  endtask

  task automatic t_empty;
    apply(8'h00, 8'h00, 8'h00, 0, 0); check_valid("R3 empty", 1'b0, 3'd0);
    apply(8'h00, 8'h00, 8'hFF, 1, 1); check_valid("R3 empty with isv", 1'b0, 3'd0);
  endtask

  task automatic t_strict;
    set_pri(3'd7);
    apply(8'h08, 8'h00, 8'h08, 0, 0); check_valid("R4 tie", 1'b0, 3'd0);
    apply(8'h04, 8'h00, 8'h08, 0, 0); check_valid("R4 better than isv", 1'b1, 3'd2);
    apply(8'h20, 8'h00, 8'h08, 0, 0); check_valid("R4 worse than isv", 1'b0, 3'd0);
    apply(8'h80, 8'h00, 8'h00, 0, 0); check_valid("R5 idle raise", 1'b1, 3'd7);
  endtask

  task automatic t_nest;
    apply(8'h08, 8'h00, 8'h04, 1, 1); check_valid("R6 cascade ignored", 1'b1, 3'd3);
    apply(8'h08, 8'h00, 8'h04, 1, 0); check_valid("R6 not master", 1'b0, 3'd0);
    apply(8'h08, 8'h00, 8'h04, 0, 1); check_valid("R6 nest off", 1'b0, 3'd0);
    apply(8'h08, 8'h00, 8'h06, 1, 1); check_valid("R6 line1 still blocks", 1'b0, 3'd0);
  endtask

  task automatic t_commands;
    @(negedge clk);
    svc_line = 3'd6; svc_rot_load = 1'b1;
    @(negedge clk);
    svc_rot_load = 1'b0; exp_base = 3'd7; #1;
    check_base("R7 service line6");
    apply(8'h81, 8'h00, 8'h00, 0, 0); check_valid("R7 line6 now lowest neighbour", 1'b1, 3'd7);
    @(negedge clk);
    svc_line = 3'd7; svc_rot_load = 1'b1;
    @(negedge clk);
    svc_rot_load = 1'b0; exp_base = 3'd0; #1;
    check_base("R7 service wrap");
    set_pri(3'd7); check_base("R8 setpri 7");
    set_pri(3'd2); check_base("R8 setpri 2");
    @(negedge clk);
    svc_line = 3'd1; svc_rot_load = 1'b1; setpri_val = 3'd4; setpri_load = 1'b1;
    @(negedge clk);
    svc_rot_load = 1'b0; setpri_load = 1'b0; exp_base = 3'd5; #1;
    check_base("R9 both strobes");
    apply(8'hA5, 8'h0F, 8'h10, 1, 1);
    apply(8'h3C, 8'hC3, 8'h01, 0, 1);
    @(negedge clk); #1;
    check_base("R10 hold without strobe");
  endtask

  task automatic t_sweep;
    logic [31:0] lf;
    lf = 32'h1234_5678;
    for (int n = 0; n < 200; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (n % 10 == 0) set_pri(lf[2:0]);
      apply(lf[7:0], lf[15:8] & lf[23:16], lf[31:24] & lf[11:4], lf[3], lf[13]);
      check_out("R2 sweep");
    end
  endtask

  initial begin
    t_reset;
    t_mask;
    t_rank;
    t_empty;
    t_strict;
    t_nest;
    t_commands;
    t_sweep;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule